// File: doc/BRIEF.md
# Saturating Fixed-Point ALU with Banked Registers

This block is the arithmetic/logic stage of a fixed-point signal-processing datapath. Each cycle it can take one X operand and one Y operand, run one of fourteen operations, and write the result into either a result register or a feedback register. The X operand comes from one of two X input registers or from an external result bus that carries other units' outputs. The Y operand comes from one of two Y input registers or from the feedback register, so a running value can be fed back without a bus transfer.

Six status flags are latched with each operation. The latched carry feeds the carry-in of the carry-using add and subtract, so wide words can be processed one slice at a time. Two divide-step operations support non-restoring division, one quotient bit per step. A mode input lets the result register clamp to the largest positive or largest negative value on signed overflow.

The registers exist as two complete banks, and a bank-select input chooses which one is visible. An interrupt handler can switch banks in one cycle and leave the interrupted context untouched. The status flags are shared between the banks.

Top module: `fxa_alu`

## Requirements
- R1: After reset, every register in both banks reads 0 and all six status flags are 0.
- R2: With `op_valid` high, opcode 0 gives X+Y, opcode 1 gives X+Y+C, opcode 2 gives X−Y and opcode 3 gives X−Y−1+C. Here C is the latched carry flag. A subtraction is computed as X + ~Y + carry-in.
- R3: Opcode 4 gives −X, opcode 5 gives X+1, opcode 6 gives X−1 and opcode 7 gives |X|, all modulo 2^16. The absolute value of 0x8000 is 0x8000.
- R4: Opcodes 8, 9, 10 and 11 give X AND Y, X OR Y, X XOR Y and NOT X. These opcodes clear the overflow and carry flags.
- R5: The status output holds zero at bit 0, negative at bit 1, overflow at bit 2, carry at bit 3, sign at bit 4 and quotient at bit 5. Opcodes 0 to 11 set zero and negative from the unsaturated result. Opcodes 0 to 7 set overflow on signed two's-complement overflow and set carry to the adder carry-out; for a subtraction, carry 1 means no borrow.
- R6: The sign flag takes the sign bit of X on opcode 7 and holds its value on every other cycle.
- R7: Opcode 12 (divide start) sets Q = X[15] XOR Y[15] and gives {X[14:0], Q}. Opcode 13 (divide step) computes T = X+Y when the latched Q is 1 and T = X−Y when it is 0; it then sets Q = T[15] XOR Y[15] and gives {T[14:0], Q}. Only the quotient flag changes on opcodes 12 and 13, and no other operation changes it.
- R8: `x_sel` 0 picks X register 0, 1 picks X register 1, and 2 or 3 picks `rbus`. `y_sel` 0 picks Y register 0, 1 picks Y register 1, and 2 or 3 picks the feedback register.
- R9: A result goes to the feedback register when `dst_af` is 1 and to the result register when it is 0. It becomes visible on the outputs one cycle after the operation.
- R10: When `sat_mode` is 1 and opcodes 0 to 7 overflow with the result register as destination, that register receives 0x7FFF if the wrapped result is negative and 0x8000 if it is non-negative. The feedback register never saturates.
- R11: `bank_sel` picks the bank that operands are read from, that results and loads are written to, and that drives `ar_out` and `af_out`. The other bank keeps its contents.
- R12: With `ld_en` high, `ld_data` is written into the register named by `ld_sel`: 0 X0, 1 X1, 2 Y0, 3 Y1, 4 feedback, 5 result. Values 6 and 7 write nothing. When a load and an operation target the same register in one cycle, the operation's result is kept.
- R13: A cycle with `op_valid` low, or with opcode 14 or 15, changes no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load a register from `ld_data` |
| ld_sel | input | 3 | Register chosen for the load |
| ld_data | input | 16 | Load value from the data bus |
| rbus | input | 16 | Result bus from other units, usable as X |
| op_valid | input | 1 | Execute `op` this cycle |
| op | input | 4 | Operation code |
| x_sel | input | 2 | X operand source |
| y_sel | input | 2 | Y operand source |
| dst_af | input | 1 | 1 writes the feedback register, 0 the result register |
| sat_mode | input | 1 | Enables result-register saturation |
| bank_sel | input | 1 | Active register bank |
| status | output | 6 | Latched flags {Q,S,C,V,N,Z} |
| ar_out | output | 16 | Result register of the active bank |
| af_out | output | 16 | Feedback register of the active bank |

## Verification
The assertions check on every cycle the rules that need no arithmetic. Flags and the result register must stay put on idle or undefined cycles. The sign and quotient flags may change only on their own opcodes. Logic operations must leave overflow and carry clear, and zero and negative are never set together. A saturating write that overflowed must leave one of the two limit values. Only the bench's scenarios can show that results are numerically correct, that multiword carry chains work, that a divide sequence proceeds, and that one bank's contents survive work in the other bank.

// File: rtl/fxa_pkg.sv
package fxa_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBC  = 4'd3,
      OP_NEG  = 4'd4,
      OP_INC  = 4'd5,
      OP_DEC  = 4'd6,
      OP_ABS  = 4'd7,
      OP_AND  = 4'd8,
      OP_OR   = 4'd9,
      OP_XOR  = 4'd10,
      OP_NOT  = 4'd11,
      OP_DIVS = 4'd12,
      OP_DIVQ = 4'd13,
      OP_RSV0 = 4'd14,
      OP_RSV1 = 4'd15
   } fxa_op_e;

   localparam int FL_Z  = 0;
   localparam int FL_N  = 1;
   localparam int FL_V  = 2;
   localparam int FL_C  = 3;
   localparam int FL_S  = 4;
   localparam int FL_Q  = 5;
   localparam int NFLAG = 6;

   localparam int RI_X0 = 0;
   localparam int RI_X1 = 1;
   localparam int RI_Y0 = 2;
   localparam int RI_Y1 = 3;
   localparam int RI_AF = 4;
   localparam int RI_AR = 5;
   localparam int NREG  = 6;

   function automatic logic op_is_arith(input logic [3:0] o);
      return o <= 4'd7;
   endfunction

   function automatic logic op_is_logic(input logic [3:0] o);
      return (o >= 4'd8) && (o <= 4'd11);
   endfunction

   function automatic logic op_is_div(input logic [3:0] o);
      return (o == 4'd12) || (o == 4'd13);
   endfunction

   function automatic logic op_is_known(input logic [3:0] o);
      return o <= 4'd13;
   endfunction

endpackage

// File: rtl/fxa_bank.sv
module fxa_bank
   import fxa_pkg::*;
#(
   parameter int W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_we,
   input  logic [2:0]                 ld_idx,
   input  logic [W-1:0]               ld_val,
   input  logic                       rs_we,
   input  logic [2:0]                 rs_idx,
   input  logic [W-1:0]               rs_val,
   output logic [NREG-1:0][W-1:0]     rf_q
);

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rf_q[i] <= '0;
         end else if (rs_we && (rs_idx == 3'(i))) begin
            rf_q[i] <= rs_val;   // operation result has priority over a load
         end else if (ld_we && (ld_idx == 3'(i))) begin
            rf_q[i] <= ld_val;
         end
      end
   end

endmodule

// File: rtl/fxa_arith.sv
module fxa_arith
   import fxa_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [3:0]   op,
   input  logic         ac_in,
   input  logic         aq_in,
   output logic [W-1:0] res,
   output logic         ov,
   output logic         co,
   output logic         q_out
);

   logic [W-1:0] a_op;
   logic [W-1:0] b_op;
   logic         c_op;
   logic [W:0]   sum;
   logic         ov_raw;

   // operand steering for the single shared adder
   always_comb begin
      a_op = x;
      b_op = '0;
      c_op = 1'b0;
      unique case (op)
         OP_ADD:  begin b_op = y;         end
         OP_ADC:  begin b_op = y;  c_op = ac_in; end
         OP_SUB:  begin b_op = ~y; c_op = 1'b1;  end
         OP_SBC:  begin b_op = ~y; c_op = ac_in; end
         OP_NEG:  begin a_op = '0; b_op = ~x; c_op = 1'b1; end
         OP_INC:  begin c_op = 1'b1; end
         OP_DEC:  begin b_op = '1; end
         OP_ABS:  begin
            if (x[W-1]) begin
               a_op = '0; b_op = ~x; c_op = 1'b1;
            end
         end
         OP_DIVQ: begin
            b_op = aq_in ? y : ~y;
            c_op = ~aq_in;
         end
         default: begin end
      endcase
   end

   assign sum    = {1'b0, a_op} + {1'b0, b_op} + {{W{1'b0}}, c_op};
   assign ov_raw = (a_op[W-1] == b_op[W-1]) && (sum[W-1] != a_op[W-1]);

   // result selection
   always_comb begin
      res   = sum[W-1:0];
      q_out = aq_in;
      ov    = 1'b0;
      co    = 1'b0;
      if (op_is_arith(op)) begin
         ov = ov_raw;
         co = sum[W];
      end
      unique case (op)
         OP_AND:  res = x & y;
         OP_OR:   res = x | y;
         OP_XOR:  res = x ^ y;
         OP_NOT:  res = ~x;
         OP_DIVS: begin
            q_out = x[W-1] ^ y[W-1];
            res   = {x[W-2:0], q_out};
         end
         OP_DIVQ: begin
            q_out = sum[W-1] ^ y[W-1];
            res   = {sum[W-2:0], q_out};
         end
         default: begin end
      endcase
   end

endmodule

// File: rtl/fxa_sat.sv
module fxa_sat #(
   parameter int W      = 16,
   parameter bit SAT_EN = 1'b1
) (
   input  logic [W-1:0] raw,
   input  logic         ovf,
   input  logic         en,
   output logic [W-1:0] val
);

   localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

   if (SAT_EN) begin : g_clamp
      // a wrapped negative value means the true result went above the top
      always_comb begin
         if (en && ovf) val = raw[W-1] ? MAX_POS : MAX_NEG;
         else           val = raw;
      end
   end else begin : g_pass
      logic unused_sat;
      assign unused_sat = en & ovf;
      assign val = raw;
   end

endmodule

// File: rtl/fxa_alu.sv
module fxa_alu
   import fxa_pkg::*;
#(
   parameter  int W      = 16,
   parameter  int BANKS  = 2,
   parameter  bit SAT_EN = 1'b1,
   localparam int BSW    = $clog2(BANKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [2:0]       ld_sel,
   input  logic [W-1:0]     ld_data,
   input  logic [W-1:0]     rbus,
   input  logic             op_valid,
   input  logic [3:0]       op,
   input  logic [1:0]       x_sel,
   input  logic [1:0]       y_sel,
   input  logic             dst_af,
   input  logic             sat_mode,
   input  logic [BSW-1:0]   bank_sel,
   output logic [NFLAG-1:0] status,
   output logic [W-1:0]     ar_out,
   output logic [W-1:0]     af_out
);

   if (W < 4) begin : g_bad_width
      $error("fxa_alu: W must be at least 4");
   end
   if ((BANKS < 2) || (BANKS != (1 << BSW))) begin : g_bad_banks
      $error("fxa_alu: BANKS must be a power of two, at least 2");
   end

   logic [BANKS-1:0][NREG-1:0][W-1:0] rf_all;
   logic [NREG-1:0][W-1:0]            act;
   logic [W-1:0]                      x_opnd;
   logic [W-1:0]                      y_opnd;
   logic [W-1:0]                      raw_res;
   logic [W-1:0]                      sat_res;
   logic [W-1:0]                      wr_val;
   logic [2:0]                        wr_idx;
   logic                              ovf;
   logic                              cout;
   logic                              q_next;
   logic                              exec;
   logic                              ld_ok;
   logic [NFLAG-1:0]                  flags;

   assign exec  = op_valid && op_is_known(op);
   assign ld_ok = ld_en && (ld_sel < 3'(NREG));

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic here;
      assign here = (bank_sel == BSW'(b));
      fxa_bank #(.W(W)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld_we  (ld_ok && here),
         .ld_idx (ld_sel),
         .ld_val (ld_data),
         .rs_we  (exec && here && !op_is_div(op) ? 1'b1 : (exec && here)),
         .rs_idx (wr_idx),
         .rs_val (wr_val),
         .rf_q   (rf_all[b])
      );
   end

   assign act = rf_all[bank_sel];

   // operand selection
   always_comb begin
      if (x_sel[1]) x_opnd = rbus;
      else          x_opnd = x_sel[0] ? act[RI_X1] : act[RI_X0];
      if (y_sel[1]) y_opnd = act[RI_AF];
      else          y_opnd = y_sel[0] ? act[RI_Y1] : act[RI_Y0];
   end

   fxa_arith #(.W(W)) u_arith (
      .x     (x_opnd),
      .y     (y_opnd),
      .op    (op),
      .ac_in (flags[FL_C]),
      .aq_in (flags[FL_Q]),
      .res   (raw_res),
      .ov    (ovf),
      .co    (cout),
      .q_out (q_next)
   );

   fxa_sat #(.W(W), .SAT_EN(SAT_EN)) u_sat (
      .raw (raw_res),
      .ovf (ovf),
      .en  (sat_mode && op_is_arith(op) && !dst_af),
      .val (sat_res)
   );

   assign wr_idx = dst_af ? 3'(RI_AF) : 3'(RI_AR);
   assign wr_val = dst_af ? raw_res : sat_res;

   // shared status flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else if (exec) begin
         if (op_is_div(op)) begin
            flags[FL_Q] <= q_next;
         end else begin
            flags[FL_Z] <= (raw_res == '0);
            flags[FL_N] <= raw_res[W-1];
            flags[FL_V] <= ovf;
            flags[FL_C] <= cout;
            if (op == OP_ABS) flags[FL_S] <= x_opnd[W-1];
         end
      end
   end

   assign status = flags;
   assign ar_out = act[RI_AR];
   assign af_out = act[RI_AF];

endmodule

// File: rtl/fxa_chk.sv
module fxa_chk #(
   parameter int W   = 16,
   parameter int BSW = 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           op_valid,
   input logic [3:0]     op,
   input logic           dst_af,
   input logic           sat_mode,
   input logic [BSW-1:0] bank_sel,
   input logic           ld_en,
   input logic [5:0]     status,
   input logic [W-1:0]   ar_out
);

   localparam logic [W-1:0] TOP = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] BOT = {1'b1, {(W-1){1'b0}}};

   AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && op <= 4'd13) |=> $stable(status)); // R13

   AST_IDLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (!(op_valid && op <= 4'd13) && !ld_en) |=> ((bank_sel != $past(bank_sel)) || $stable(ar_out))); // R13

   AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op >= 4'd8 && op <= 4'd11) |=> (!status[2] && !status[3])); // R4

   AST_SIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && op == 4'd7) |=> $stable(status[4])); // R6

   AST_QUOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && (op == 4'd12 || op == 4'd13)) |=> $stable(status[5])); // R7

   AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op <= 4'd7 && !dst_af && sat_mode)
      |=> ((bank_sel != $past(bank_sel)) || !status[2] || ar_out == TOP || ar_out == BOT)); // R10

   AST_ZN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      status[0] |-> !status[1]); // R5

endmodule

bind fxa_alu fxa_chk #(.W(W), .BSW(BSW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op       (op),
   .dst_af   (dst_af),
   .sat_mode (sat_mode),
   .bank_sel (bank_sel),
   .ld_en    (ld_en),
   .status   (status),
   .ar_out   (ar_out)
);

// File: tb/tb_fxa_alu.sv
`timescale 1ns/1ps
module tb_fxa_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic [2:0]  ld_sel = '0;
   logic [15:0] ld_data = '0;
   logic [15:0] rbus = '0;
   logic        op_valid = 1'b0;
   logic [3:0]  op = '0;
   logic [1:0]  x_sel = '0;
   logic [1:0]  y_sel = '0;
   logic        dst_af = 1'b0;
   logic        sat_mode = 1'b0;
   logic        bank_sel = 1'b0;
   logic [5:0]  status;
   logic [15:0] ar_out;
   logic [15:0] af_out;

   int checks = 0;
   int fails  = 0;

   logic [15:0] mr [2][6];
   logic [5:0]  mf;

   always #5 clk = ~clk;

   fxa_alu dut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
      .rbus(rbus), .op_valid(op_valid), .op(op), .x_sel(x_sel), .y_sel(y_sel),
      .dst_af(dst_af), .sat_mode(sat_mode), .bank_sel(bank_sel),
      .status(status), .ar_out(ar_out), .af_out(af_out)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference behaviour written from the requirements
   task automatic model(input logic v, input logic [3:0] o, input logic [1:0] xs, input logic [1:0] ys,
                        input logic daf, input logic [15:0] rb, input logic sm, input logic bk,
                        input logic le, input logic [2:0] ls, input logic [15:0] ld);
      logic [15:0] x, y, res, t;
      logic [16:0] full;
      int sx, sy, sr;
      logic ovf, q;
      x  = xs[1] ? rb : mr[bk][xs[0]];
      y  = ys[1] ? mr[bk][4] : mr[bk][2 + int'(ys[0])];
      sx = int'($signed(x));
      sy = int'($signed(y));
      full = '0; sr = 0; res = '0; q = mf[5];
      case (o)
         4'd0: begin full = {1'b0,x} + {1'b0,y}; sr = sx + sy; end
         4'd1: begin full = {1'b0,x} + {1'b0,y} + {16'd0,mf[3]}; sr = sx + sy + (mf[3] ? 1 : 0); end
         4'd2: begin full = {1'b0,x} + {1'b0,~y} + 17'd1; sr = sx - sy; end
         4'd3: begin full = {1'b0,x} + {1'b0,~y} + {16'd0,mf[3]}; sr = sx - sy - 1 + (mf[3] ? 1 : 0); end
         4'd4: begin full = {1'b0,~x} + 17'd1; sr = -sx; end
         4'd5: begin full = {1'b0,x} + 17'd1; sr = sx + 1; end
         4'd6: begin full = {1'b0,x} + 17'h0FFFF; sr = sx - 1; end
         4'd7: begin
            if (x[15]) begin full = {1'b0,~x} + 17'd1; sr = -sx; end
            else       begin full = {1'b0,x}; sr = sx; end
         end
         4'd8:  res = x & y;
         4'd9:  res = x | y;
         4'd10: res = x ^ y;
         4'd11: res = ~x;
         4'd12: begin q = x[15] ^ y[15]; res = {x[14:0], q}; end
         4'd13: begin
            t = mf[5] ? (x + y) : (x - y);
            q = t[15] ^ y[15];
            res = {t[14:0], q};
         end
         default: ;
      endcase
      if (o <= 4'd7) res = full[15:0];
      ovf = (o <= 4'd7) && ((sr > 32767) || (sr < -32768));
      if (le && ls < 3'd6) mr[bk][ls] = ld;
      if (v && o <= 4'd13) begin
         if (daf) mr[bk][4] = res;
         else if (sm && o <= 4'd7 && ovf) mr[bk][5] = res[15] ? 16'h7FFF : 16'h8000;
         else mr[bk][5] = res;
         if (o >= 4'd12) mf[5] = q;
         else begin
            mf[0] = (res == 16'd0);
            mf[1] = res[15];
            mf[2] = ovf;
            mf[3] = (o <= 4'd7) ? full[16] : 1'b0;
            if (o == 4'd7) mf[4] = x[15];
         end
      end
   endtask

   task automatic cyc(input logic v, input logic [3:0] o, input logic [1:0] xs, input logic [1:0] ys,
                      input logic daf, input logic [15:0] rb, input logic sm, input logic bk,
                      input logic le, input logic [2:0] ls, input logic [15:0] ld, input string tag);
      op_valid = v; op = o; x_sel = xs; y_sel = ys; dst_af = daf; rbus = rb;
      sat_mode = sm; bank_sel = bk; ld_en = le; ld_sel = ls; ld_data = ld;
      model(v, o, xs, ys, daf, rb, sm, bk, le, ls, ld);
      @(negedge clk);
      check({tag, " ar_out"}, ar_out, mr[bk][5]);
      check({tag, " af_out"}, af_out, mr[bk][4]);
      check({tag, " R5 status"}, {10'd0, status}, {10'd0, mf});
   endtask

   task automatic load(input logic bk, input logic [2:0] ls, input logic [15:0] d);
      cyc(1'b0, 4'd0, 2'd0, 2'd0, 1'b0, 16'd0, 1'b0, bk, 1'b1, ls, d, "R12 load");
   endtask

   task automatic exe(input logic [3:0] o, input logic [1:0] xs, input logic [1:0] ys, input logic daf,
                      input logic sm, input logic bk, input string tag);
      cyc(1'b1, o, xs, ys, daf, 16'd0, sm, bk, 1'b0, 3'd0, 16'd0, tag);
   endtask

   function automatic logic [15:0] rv();
      case ($urandom % 6)
         0: return 16'h0000;
         1: return 16'h7FFF;
         2: return 16'h8000;
         3: return 16'hFFFF;
         4: return 16'h0001;
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin
      #1_000_000;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd7741));
      for (int b = 0; b < 2; b++) for (int r = 0; r < 6; r++) mr[b][r] = '0;
      mf = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset ar", ar_out, 16'h0);
      check("R1 reset af", af_out, 16'h0);
      check("R1 reset status", {10'd0, status}, 16'h0);

      // saturation corners
      load(1'b0, 3'd0, 16'h7FFF);
      load(1'b0, 3'd2, 16'h0001);
      exe(4'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R2 add wrap");
      check("R10 wrap without sat", ar_out, 16'h8000);
      check("R5 overflow flag", {15'd0, status[2]}, 16'd1);
      exe(4'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, "R10 sat pos");
      check("R10 clamp positive", ar_out, 16'h7FFF);
      exe(4'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, "R9 af no sat");
      check("R10 feedback unsaturated", af_out, 16'h8000);
      load(1'b0, 3'd1, 16'h8000);
      load(1'b0, 3'd3, 16'h0001);
      exe(4'd2, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0, "R10 sat neg");
      check("R10 clamp negative", ar_out, 16'h8000);

      // carry chain
      load(1'b0, 3'd0, 16'hFFFF);
      load(1'b0, 3'd1, 16'h0000);
      load(1'b0, 3'd3, 16'h0000);
      exe(4'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R2 add carry");
      check("R2 carry out", {15'd0, status[3]}, 16'd1);
      exe(4'd1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, "R2 adc");
      check("R2 adc uses carry", ar_out, 16'h0001);

      // absolute value of the most negative number
      load(1'b0, 3'd0, 16'h8000);
      exe(4'd7, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R3 abs");
      check("R6 sign of x", {15'd0, status[4]}, 16'd1);
      check("R3 abs min", ar_out, 16'h8000);
      exe(4'd5, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R6 sign held R3");
      check("R6 sign held", {15'd0, status[4]}, 16'd1);

      // operand from result bus, feedback as Y
      cyc(1'b1, 4'd9, 2'd2, 2'd2, 1'b1, 16'h0F00, 1'b0, 1'b0, 1'b0, 3'd0, 16'd0, "R8 rbus");
      cyc(1'b1, 4'd8, 2'd3, 2'd2, 1'b0, 16'hFF0F, 1'b0, 1'b0, 1'b0, 3'd0, 16'd0, "R8 af as y R4");

      // bank isolation
      load(1'b0, 3'd5, 16'h1234);
      load(1'b1, 3'd7, 16'hDEAD);
      check("R11 other bank ar", ar_out, 16'h0000);
      load(1'b1, 3'd5, 16'h5678);
      exe(4'd14, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R13 undefined");
      check("R11 bank0 kept", ar_out, 16'h1234);

      // divide sequence
      load(1'b0, 3'd0, 16'h0300);
      load(1'b0, 3'd2, 16'h0100);
      exe(4'd12, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, "R7 divs");
      for (int k = 0; k < 6; k++) exe(4'd13, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0, "R7 divq");

      // load vs result collision
      cyc(1'b1, 4'd5, 2'd0, 2'd0, 1'b0, 16'd0, 1'b0, 1'b0, 1'b1, 3'd5, 16'hAAAA, "R12 collide");

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] o;
         string tg;
         o = 4'($urandom);
         if (o <= 4'd3) tg = "R2 rnd";
         else if (o <= 4'd7) tg = "R3 rnd";
         else if (o <= 4'd11) tg = "R4 rnd";
         else if (o <= 4'd13) tg = "R7 rnd";
         else tg = "R13 rnd";
         cyc(($urandom % 8) != 0, o, 2'($urandom), 2'($urandom), 1'($urandom), rv(),
             1'($urandom), (($urandom % 16) == 0) ? ~bank_sel : bank_sel,
             ($urandom % 3) == 0, 3'($urandom), rv(), tg);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule